// File: doc/BRIEF.md
# Fence Descriptor Update Sequencer

This block programs one 64-bit detiling fence descriptor through a 32-bit register write port. A request gives the region start, the region size, the surface stride, the tiling mode (X or Y) and an enable flag. The block checks the request, encodes the two descriptor words and then runs a fixed sequence of writes and readbacks. Because of this order, logic that watches the fence never sees an enabled descriptor that is only half updated.

The sequence has five steps. First the low word is forced to zero, which disables the fence. That write is confirmed by a readback. Next the high word is written, and after it the low word with the valid bit set. A final readback closes the sequence. Each step waits for its handshake before the next one starts. A request with the enable flag clear writes zeros to both words. A request that breaks the alignment rules is refused at once. A refused request raises an error flag and causes no bus traffic.

Top module: `fence_update_seq`

## Requirements
- R1: The high word written equals start + size - 4096, which is the base address of the last 4 KiB page of the region.
- R2: The final low word written holds start bits [31:12] in bits [31:12], the value stride/128 - 1 in the pitch field at bits [PITCH_SHIFT +: PITCH_W] (default bits [11:2]), the Y-tiling flag in bit 1 (1 = Y, 0 = X) and a 1 in valid bit 0.
- R3: An accepted request with the enable flag clear writes 0 to both the high word and the final low word.
- R4: Bus events come in exactly this order: write 0 to the low address, read the low address, read acknowledge, write the high address, write the low address, read the low address, read acknowledge. No low-word write with bit 0 set comes before the high-word write of the same sequence.
- R5: A write request holds its valid, address and data steady until wrReady is seen. A read request holds its valid until rdReady is seen.
- R6: No write or read request is issued while a readback is waiting for rdAck.
- R7: busy is high from the cycle after a request is accepted until the final acknowledge. done is a one-cycle pulse in the cycle after the final acknowledge, with busy already low.
- R8: A request presented while busy is ignored. The running sequence and its values are unchanged.
- R9: An enabled request is refused when start or size is not 4 KiB aligned, size is zero, stride is zero or not a multiple of 128, or stride/128 - 1 does not fit in PITCH_W bits. A refused request sets errFlag in the next cycle, leaves busy low and issues no bus event.
- R10: errFlag stays set until the next accepted request, which clears it in the cycle after acceptance.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Request strobe, taken when idle |
| reqEnable | input | 1 | 1 = program the fence, 0 = clear it |
| reqStart | input | 32 | Region start address |
| reqSize | input | 32 | Region size in bytes |
| reqStride | input | STRIDE_W | Surface stride in bytes |
| reqTileY | input | 1 | 1 = Y tiling, 0 = X tiling |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | One-cycle completion pulse |
| errFlag | output | 1 | Last request was refused |
| wrValid | output | 1 | Register write request |
| wrAddr | output | REG_ADDR_W | Register write address |
| wrData | output | 32 | Register write data |
| wrReady | input | 1 | Write accepted |
| rdValid | output | 1 | Readback request |
| rdAddr | output | REG_ADDR_W | Readback address (low word) |
| rdReady | input | 1 | Readback request accepted |
| rdAck | input | 1 | Readback response returned |

## Verification
The assertions assume that the register port raises rdAck only while a readback is outstanding, and that it raises rdAck at most once for each accepted read. The bench's bus model follows this rule: it counts accepted reads and issues one acknowledge per read, after a random delay. The assertions also assume that addresses stay inside 32 bits. The random requests keep start + size well below 2^32. wrReady and rdReady are randomised on every cycle, so the hold rules are exercised under back-pressure.

// File: rtl/fence_pkg.sv
package fence_pkg;
  localparam int PAGE_BITS = 12;
  localparam int WORD_W    = 32;

  typedef enum logic [1:0] {
    SEL_ZERO = 2'd0,
    SEL_HI   = 2'd1,
    SEL_LO   = 2'd2
  } wrSel_e;

  typedef struct packed {
    logic   load;
    wrSel_e sel;
  } ctrlStrobe_t;
endpackage

// File: rtl/fence_datapath.sv
module fence_datapath
  import fence_pkg::*;
#(
  parameter int STRIDE_W    = 18,
  parameter int PITCH_W     = 10,
  parameter int PITCH_SHIFT = 2,
  parameter int TILE_Y_BIT  = 1,
  parameter int REG_ADDR_W  = 8,
  parameter logic [REG_ADDR_W-1:0] LO_ADDR = 'h0,
  parameter logic [REG_ADDR_W-1:0] HI_ADDR = 'h4
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  ctrlStrobe_t           strobe,
  input  logic                  reqEnable,
  input  logic [WORD_W-1:0]     reqStart,
  input  logic [WORD_W-1:0]     reqSize,
  input  logic [STRIDE_W-1:0]   reqStride,
  input  logic                  reqTileY,
  output logic                  reqOk,
  output logic [REG_ADDR_W-1:0] wrAddr,
  output logic [WORD_W-1:0]     wrData,
  output logic [REG_ADDR_W-1:0] rdAddr
);
  localparam int CNT_W = STRIDE_W - 7;
  localparam logic [WORD_W-1:0] PAGE_BYTES = WORD_W'(1) << PAGE_BITS;

  logic [CNT_W-1:0]  pitchCnt;
  logic [CNT_W-1:0]  pitchM1;
  logic              pitchFits;
  logic              aligned;
  logic [WORD_W-1:0] hiNext;
  logic [WORD_W-1:0] loNext;
  logic [WORD_W-1:0] hiReg;
  logic [WORD_W-1:0] loReg;

  assign pitchCnt = reqStride[STRIDE_W-1:7];
  assign pitchM1  = pitchCnt - CNT_W'(1);

  generate
    if (CNT_W > PITCH_W) begin : g_wide
      assign pitchFits = (pitchM1[CNT_W-1:PITCH_W] == '0);
    end else begin : g_narrow
      assign pitchFits = 1'b1;
    end
  endgenerate

  assign aligned = (reqStart[PAGE_BITS-1:0] == '0) && (reqSize[PAGE_BITS-1:0] == '0)
                && (reqSize != '0) && (reqStride[6:0] == '0) && (pitchCnt != '0);
  assign reqOk   = !reqEnable || (aligned && pitchFits);

  always_comb begin
    hiNext = '0;
    loNext = '0;
    if (reqEnable) begin
      hiNext = reqStart + reqSize - PAGE_BYTES;
      loNext = {reqStart[WORD_W-1:PAGE_BITS], {PAGE_BITS{1'b0}}};
      loNext[PITCH_SHIFT +: PITCH_W] = pitchM1[PITCH_W-1:0];
      loNext[TILE_Y_BIT] = reqTileY;
      loNext[0] = 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      hiReg <= '0;
      loReg <= '0;
    end else if (strobe.load) begin
      hiReg <= hiNext;
      loReg <= loNext;
    end
  end

  always_comb begin
    wrAddr = LO_ADDR;
    wrData = '0;
    case (strobe.sel)
      SEL_HI:  begin wrAddr = HI_ADDR; wrData = hiReg; end
      SEL_LO:  begin wrAddr = LO_ADDR; wrData = loReg; end
      default: begin wrAddr = LO_ADDR; wrData = '0;    end
    endcase
  end

  assign rdAddr = LO_ADDR;

  AST_LOAD_ONLY_OK: assert property (@(posedge clk) disable iff (!rstN)
    strobe.load |-> reqOk); // R9
endmodule

// File: rtl/fence_ctrl.sv
module fence_ctrl
  import fence_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        reqValid,
  input  logic        reqOk,
  input  logic        wrReady,
  input  logic        rdReady,
  input  logic        rdAck,
  output logic        wrValid,
  output logic        rdValid,
  output logic        busy,
  output logic        done,
  output logic        errFlag,
  output ctrlStrobe_t strobe
);
  typedef enum logic [2:0] {
    S_IDLE, S_WR_OFF, S_RD_OFF, S_ACK_OFF, S_WR_HI, S_WR_LO, S_RD_FIN, S_ACK_FIN
  } state_e;

  state_e state;
  state_e stateNext;
  logic   accept;

  assign accept = (state == S_IDLE) && reqValid && reqOk;

  always_comb begin
    stateNext = state;
    case (state)
      S_IDLE:    if (accept)  stateNext = S_WR_OFF;
      S_WR_OFF:  if (wrReady) stateNext = S_RD_OFF;
      S_RD_OFF:  if (rdReady) stateNext = S_ACK_OFF;
      S_ACK_OFF: if (rdAck)   stateNext = S_WR_HI;
      S_WR_HI:   if (wrReady) stateNext = S_WR_LO;
      S_WR_LO:   if (wrReady) stateNext = S_RD_FIN;
      S_RD_FIN:  if (rdReady) stateNext = S_ACK_FIN;
      S_ACK_FIN: if (rdAck)   stateNext = S_IDLE;
      default:                stateNext = S_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state   <= S_IDLE;
      done    <= 1'b0;
      errFlag <= 1'b0;
    end else begin
      state <= stateNext;
      done  <= (state == S_ACK_FIN) && rdAck;
      if ((state == S_IDLE) && reqValid) errFlag <= !reqOk;
    end
  end

  assign busy    = (state != S_IDLE);
  assign wrValid = (state == S_WR_OFF) || (state == S_WR_HI) || (state == S_WR_LO);
  assign rdValid = (state == S_RD_OFF) || (state == S_RD_FIN);

  always_comb begin
    strobe.load = accept;
    case (state)
      S_WR_HI: strobe.sel = SEL_HI;
      S_WR_LO: strobe.sel = SEL_LO;
      default: strobe.sel = SEL_ZERO;
    endcase
  end

  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done); // R7
  AST_DONE_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    done |-> !busy); // R7
  AST_ERR_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    $rose(errFlag) |-> !busy && !wrValid && !rdValid); // R9
  AST_ACK_WAIT_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    (rdValid && rdReady) |=> !wrValid && !rdValid); // R6
  AST_BUSY_HOLDS: assert property (@(posedge clk) disable iff (!rstN)
    (busy && !rdAck) |=> busy); // R8
endmodule

// File: rtl/fence_update_seq.sv
module fence_update_seq
  import fence_pkg::*;
#(
  parameter int STRIDE_W    = 18,
  parameter int PITCH_W     = 10,
  parameter int PITCH_SHIFT = 2,
  parameter int TILE_Y_BIT  = 1,
  parameter int REG_ADDR_W  = 8,
  parameter logic [REG_ADDR_W-1:0] LO_ADDR = 'h0,
  parameter logic [REG_ADDR_W-1:0] HI_ADDR = 'h4
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  reqValid,
  input  logic                  reqEnable,
  input  logic [31:0]           reqStart,
  input  logic [31:0]           reqSize,
  input  logic [STRIDE_W-1:0]   reqStride,
  input  logic                  reqTileY,
  output logic                  busy,
  output logic                  done,
  output logic                  errFlag,
  output logic                  wrValid,
  output logic [REG_ADDR_W-1:0] wrAddr,
  output logic [31:0]           wrData,
  input  logic                  wrReady,
  output logic                  rdValid,
  output logic [REG_ADDR_W-1:0] rdAddr,
  input  logic                  rdReady,
  input  logic                  rdAck
);
  ctrlStrobe_t strobe;
  logic        reqOk;

  fence_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqOk(reqOk),
    .wrReady(wrReady), .rdReady(rdReady), .rdAck(rdAck),
    .wrValid(wrValid), .rdValid(rdValid), .busy(busy), .done(done),
    .errFlag(errFlag), .strobe(strobe)
  );

  fence_datapath #(
    .STRIDE_W(STRIDE_W), .PITCH_W(PITCH_W), .PITCH_SHIFT(PITCH_SHIFT),
    .TILE_Y_BIT(TILE_Y_BIT), .REG_ADDR_W(REG_ADDR_W),
    .LO_ADDR(LO_ADDR), .HI_ADDR(HI_ADDR)
  ) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .reqEnable(reqEnable),
    .reqStart(reqStart), .reqSize(reqSize), .reqStride(reqStride),
    .reqTileY(reqTileY), .reqOk(reqOk), .wrAddr(wrAddr), .wrData(wrData),
    .rdAddr(rdAddr)
  );

  logic hiSeen;
  always_ff @(posedge clk) begin
    if (!rstN) hiSeen <= 1'b0;
    else if (strobe.load) hiSeen <= 1'b0;
    else if (wrValid && wrReady && (wrAddr == HI_ADDR)) hiSeen <= 1'b1;
  end

  AST_WR_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (wrValid && !wrReady) |=> wrValid && $stable(wrAddr) && $stable(wrData)); // R5
  AST_RD_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (rdValid && !rdReady) |=> rdValid && $stable(rdAddr)); // R5
  AST_VALID_AFTER_HI: assert property (@(posedge clk) disable iff (!rstN)
    (wrValid && (wrAddr == LO_ADDR) && wrData[0]) |-> hiSeen); // R4
  AST_ONE_CHANNEL: assert property (@(posedge clk) disable iff (!rstN)
    !(wrValid && rdValid)); // R6
endmodule

// File: tb/fence_update_seq_bench.sv
`timescale 1ns/1ps
module fence_update_seq_bench;
  localparam int SW = 18;
  localparam logic [7:0] LO = 8'h00;
  localparam logic [7:0] HI = 8'h04;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic reqValid = 0, reqEnable = 0, reqTileY = 0;
  logic [31:0] reqStart = 0, reqSize = 0;
  logic [SW-1:0] reqStride = 0;
  logic busy, done, errFlag, wrValid, rdValid;
  logic [7:0] wrAddr, rdAddr;
  logic [31:0] wrData;
  logic wrReady = 0, rdReady = 0, rdAck = 0;

  always #2.5 clk = ~clk;

  fence_update_seq u_fence_update_seq (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqEnable(reqEnable),
    .reqStart(reqStart), .reqSize(reqSize), .reqStride(reqStride),
    .reqTileY(reqTileY), .busy(busy), .done(done), .errFlag(errFlag),
    .wrValid(wrValid), .wrAddr(wrAddr), .wrData(wrData), .wrReady(wrReady),
    .rdValid(rdValid), .rdAddr(rdAddr), .rdReady(rdReady), .rdAck(rdAck)
  );

  int checks = 0;
  int fails = 0;
  int logN = 0;
  int logKind [0:31];
  logic [7:0]  logAddr [0:31];
  logic [31:0] logData [0:31];
  int rdAccepted = 0;
  int rdAcked = 0;

  // bus monitor: 0 = write, 1 = read, 2 = acknowledge
  always @(posedge clk) begin
    if (rstN) begin
      if (wrValid && wrReady && logN < 32) begin
        logKind[logN] = 0; logAddr[logN] = wrAddr; logData[logN] = wrData; logN = logN + 1;
      end
      if (rdValid && rdReady) begin
        if (logN < 32) begin
          logKind[logN] = 1; logAddr[logN] = rdAddr; logData[logN] = 0; logN = logN + 1;
        end
        rdAccepted = rdAccepted + 1;
      end
      if (rdAck && logN < 32) begin
        logKind[logN] = 2; logAddr[logN] = 0; logData[logN] = 0; logN = logN + 1;
      end
    end
  end

  // bus responder
  int ackDelay = 0;
  always @(negedge clk) begin
    wrReady <= ($urandom % 3) != 0;
    rdReady <= ($urandom % 2) != 0;
    if (rdAck) begin
      rdAck <= 1'b0;
    end else if (rdAccepted > rdAcked) begin
      if (ackDelay == 0) begin
        rdAck <= 1'b1; rdAcked = rdAcked + 1; ackDelay = $urandom % 4;
      end else ackDelay = ackDelay - 1;
    end
  end

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] expHi(logic en, logic [31:0] s, logic [31:0] z);
    return en ? s + z - 32'd4096 : 32'd0;
  endfunction

  function automatic logic [31:0] expLo(logic en, logic [31:0] s, logic [SW-1:0] st, logic y);
    logic [31:0] v;
    if (!en) return 32'd0;
    v = {s[31:12], 12'd0};
    v = v | (((32'(st) >> 7) - 32'd1) << 2);
    v = v | (32'(y) << 1) | 32'd1;
    return v;
  endfunction

  function automatic logic expOk(logic en, logic [31:0] s, logic [31:0] z, logic [SW-1:0] st);
    if (!en) return 1'b1;
    return (s[11:0] == 0) && (z[11:0] == 0) && (z != 0) && (st[6:0] == 0)
        && (st != 0) && ((32'(st) >> 7) <= 32'd1024);
  endfunction

  task automatic runReq(logic en, logic [31:0] s, logic [31:0] z, logic [SW-1:0] st,
                        logic y, logic junk);
    logic ok;
    int wd;
    ok = expOk(en, s, z, st);
    @(negedge clk);
    logN = 0;
    reqValid = 1; reqEnable = en; reqStart = s; reqSize = z; reqStride = st; reqTileY = y;
    @(negedge clk);
    reqValid = 0;
    if (!ok) begin
      check("R9 errFlag", errFlag, 1);
      repeat (3) @(negedge clk);
      check("R9 busy", busy, 0);
      check("R9 no bus events", logN, 0);
      return;
    end
    check("R7 busy after accept", busy, 1);
    check("R10 errFlag cleared", errFlag, 0);
    if (junk) begin
      reqValid = 1; reqEnable = 1; reqStart = 32'h7700_0000; reqSize = 32'h1000;
      reqStride = 18'd256; reqTileY = ~y;
      @(negedge clk);
      reqValid = 0;
    end
    wd = 0;
    while (!done && wd < 400) begin @(negedge clk); wd++; end
    check("R7 done seen", done, 1);
    check("R7 busy low with done", busy, 0);
    check("R4 event count", logN, 7);
    if (logN == 7) begin
      check("R4 ev0 kind", logKind[0], 0); check("R4 ev0 addr", logAddr[0], LO);
      check("R4 ev0 data zero", logData[0], 0);
      check("R4 ev1 read", logKind[1], 1); check("R4 ev1 addr", logAddr[1], LO);
      check("R6 ev2 ack", logKind[2], 2);
      check("R4 ev3 kind", logKind[3], 0); check("R4 ev3 addr", logAddr[3], HI);
      check(en ? "R1 high word" : "R3 high word", logData[3], expHi(en, s, z));
      check("R4 ev4 kind", logKind[4], 0); check("R4 ev4 addr", logAddr[4], LO);
      check(en ? (junk ? "R8 low word" : "R2 low word") : "R3 low word",
            logData[4], expLo(en, s, st, y));
      check("R4 ev5 read", logKind[5], 1); check("R6 ev6 ack", logKind[6], 2);
    end
    @(negedge clk);
    check("R7 done one cycle", done, 0);
  endtask

  initial begin
    void'($urandom(32'd4242));
    repeat (4) @(negedge clk);
    check("R7 reset busy", busy, 0);
    check("R7 reset done", done, 0);
    check("R9 reset errFlag", errFlag, 0);
    rstN = 1;
    @(negedge clk);
    runReq(1, 32'h0010_0000, 32'h0000_8000, 18'd512, 1, 0);
    runReq(1, 32'h0020_0000, 32'h0000_1000, 18'd128, 0, 0);
    runReq(1, 32'h0030_0000, 32'h0004_0000, 18'd131072, 1, 0);
    runReq(0, 32'h1234_5000, 32'h1000, 18'd512, 1, 0);
    runReq(1, 32'h0040_0800, 32'h1000, 18'd512, 0, 0);
    runReq(1, 32'h0040_0000, 32'h1000, 18'd192, 0, 0);
    runReq(1, 32'h0040_0000, 32'h0, 18'd512, 0, 0);
    runReq(1, 32'h0040_0000, 32'h1800, 18'd512, 0, 0);
    runReq(1, 32'h0040_0000, 32'h1000, 18'd131200, 0, 0);
    runReq(1, 32'h0050_0000, 32'h2000, 18'd1024, 0, 1);
    for (int i = 0; i < 40; i++) begin
      logic en;
      logic [31:0] s, z;
      logic [SW-1:0] st;
      en = ($urandom % 4) != 0;
      s  = ($urandom % 32'h4000) << 12;
      z  = (($urandom % 256) + 1) << 12;
      st = SW'((($urandom % 1024) + 1) * 128);
      if (($urandom % 8) == 0) s = s | 32'h40;
      runReq(en, s, z, st, $urandom % 2, ($urandom % 4) == 0);
    end
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    #(150000 * 5);
    checks++; fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule